// File: doc/BRIEF.md
# Stack call return interrupt sequencer

This block owns the stack pointer of a small 8-bit processor and performs every operation that touches the stack. These are push and pop of one data byte, absolute and relative subroutine calls, returns, return-from-interrupt, and the entry into an interrupt handler. It also owns the global interrupt-enable flag, which two instructions set and clear. The stack grows downward. A push writes at the pointer and then decrements it. A pop increments the pointer first and then reads. Return addresses take two bytes: the high byte goes to the higher address and the low byte to the one below.

The decode logic issues one operation with a single-cycle `start` pulse, together with the current PC, a call target or relative offset, and a data byte. The sequencer then uses the byte-wide RAM port once per cycle, with one state per access, followed by one completion cycle. In that cycle `done` is high, `pc_out` carries the new PC when `pc_load` is set, and `pop_data` carries a popped byte. The RAM is outside the block and has a registered read: data returns in the cycle after the read is issued.

While the sequencer is idle and no `start` is present, it samples a vector of interrupt requests. A request counts only if its bit in the enable mask is set. The lowest-numbered such request is taken as an implicit call to that vector's address.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer equals all ones (the highest RAM address), the interrupt flag is 0, and `busy` and `done` are 0.
- R2: Push (op 0) writes `wr_data` at the stack pointer and then decrements the pointer. `done` is high in the 2nd cycle after the cycle in which `start` was sampled.
- R3: Pop (op 1) increments the stack pointer, then reads that address. `pop_data` carries the byte while `done` is high, 2 cycles after `start`.
- R4: Call (op 2) and relative call (op 3) write the high byte of `pc_in`+1 at SP and decrement, then write the low byte and decrement again. In the completion cycle, 3 cycles after `start`, they assert `pc_load` with `pc_out` = `target` (op 2) or `pc_in`+`target` modulo 2^16 (op 3).
- R5: Return (op 4) pops the low byte and then the high byte, each with a pre-increment. It loads `{high, low}` with `pc_load`, 3 cycles after `start`.
- R6: Return-from-interrupt (op 5) behaves as a return and sets the interrupt flag in the cycle after `done`.
- R7: Op 6 sets the interrupt flag and op 7 clears it, one cycle after `done`. `done` comes 1 cycle after `start`, and there is no RAM access and no stack pointer change.
- R8: An interrupt request whose bit in `irq_en` is 0 is never taken. The stack pointer and `busy` are unaffected.
- R9: When idle with no `start`, the lowest-numbered enabled request is taken as a call. It pushes `pc_in`+1, loads `pc_out` = 2 + 2·index, and shows that index one-hot on `irq_ack` in the completion cycle. A `start` in the same cycle takes precedence.
- R10: A `start` arriving while `busy` is ignored. `done` is a one-cycle pulse, and `pc_load` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Issue an operation (sampled when idle) |
| op | input | 3 | Operation code (see requirements) |
| pc_in | input | 16 | Current program counter |
| target | input | 16 | Call target or relative offset |
| wr_data | input | 8 | Byte to push |
| irq_req | input | NVEC | Interrupt requests |
| irq_en | input | NVEC | Per-vector enable mask |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_re` |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | `pc_out` is to be loaded |
| pop_data | output | 8 | Popped byte (valid with `done` on a pop) |
| irq_ack | output | NVEC | One-hot acknowledge of the taken vector |
| iflag | output | 1 | Global interrupt-enable flag |
| sp_out | output | ADDR_W | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
The bench runs a push followed by a pop, and a call followed by a return. These show whether bytes land at the right addresses and come back in the right order and at the right latency. A high-then-low swap shows up as a wrong rebuilt PC. A relative call with a negative offset tells the relative mode apart from the absolute one and checks wraparound of the sum. Two interrupt patterns are used: a request with its enable off, and two enabled requests at once. They separate the enable gating from the priority choice and the vector address. A start that collides with an interrupt, and a second start issued mid-operation, test the rules for precedence and for ignoring starts while busy.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int ADDR_W   = 8,
  parameter int NVEC     = 8,
  parameter int VEC_BASE = 2,
  parameter int VEC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [15:0]       pc_in,
  input  logic [15:0]       target,
  input  logic [7:0]        wr_data,
  input  logic [NVEC-1:0]   irq_req,
  input  logic [NVEC-1:0]   irq_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       pc_out,
  output logic              pc_load,
  output logic [7:0]        pop_data,
  output logic [NVEC-1:0]   irq_ack,
  output logic              iflag,
  output logic [ADDR_W-1:0] sp_out,
  output logic              busy,
  output logic              done
);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_CALL = 3'd2, OP_RCALL = 3'd3,
                         OP_RET = 3'd4, OP_RETI = 3'd5, OP_SEI = 3'd6, OP_CLI = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_WHI, S_WLO, S_RLO, S_RHI, S_FIN} st_t;

  st_t               state;
  logic [ADDR_W-1:0] sp;
  logic [2:0]        op_q;
  logic              irq_q;
  logic [15:0]       ret_q, tgt_q;
  logic [7:0]        data_q, lo_q;
  logic [VW-1:0]     vec_q, vsel;
  logic [NVEC-1:0]   hit;

  assign hit = irq_req & irq_en;

  always_comb begin
    vsel = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (hit[i]) vsel = VW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sp     <= '1;
      iflag  <= 1'b0;
      op_q   <= OP_PUSH;
      irq_q  <= 1'b0;
      ret_q  <= '0;
      tgt_q  <= '0;
      data_q <= '0;
      lo_q   <= '0;
      vec_q  <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            op_q   <= op;
            irq_q  <= 1'b0;
            data_q <= wr_data;
            ret_q  <= pc_in + 16'd1;
            tgt_q  <= (op == OP_RCALL) ? pc_in + target : target;
            case (op)
              OP_PUSH:                 state <= S_WLO;
              OP_POP, OP_RET, OP_RETI: state <= S_RLO;
              OP_CALL, OP_RCALL:       state <= S_WHI;
              default:                 state <= S_FIN;
            endcase
          end else if (|hit) begin
            op_q  <= OP_CALL;
            irq_q <= 1'b1;
            ret_q <= pc_in + 16'd1;
            tgt_q <= 16'(VEC_BASE) + 16'(VEC_STEP) * 16'(vsel);
            vec_q <= vsel;
            state <= S_WHI;
          end
        S_WHI: begin sp <= sp - 1'b1; state <= S_WLO; end
        S_WLO: begin sp <= sp - 1'b1; state <= S_FIN; end
        S_RLO: begin sp <= sp + 1'b1; state <= (op_q == OP_POP) ? S_FIN : S_RHI; end
        S_RHI: begin sp <= sp + 1'b1; lo_q <= mem_rdata; state <= S_FIN; end
        S_FIN: begin
          state <= S_IDLE;
          if (op_q == OP_RETI || op_q == OP_SEI) iflag <= 1'b1;
          else if (op_q == OP_CLI)               iflag <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic is_ret;
  assign is_ret    = (op_q == OP_RET) || (op_q == OP_RETI);
  assign mem_we    = (state == S_WHI) || (state == S_WLO);
  assign mem_re    = (state == S_RLO) || (state == S_RHI);
  assign mem_addr  = mem_re ? sp + 1'b1 : sp;
  assign mem_wdata = (state == S_WHI) ? ret_q[15:8] : (op_q == OP_PUSH) ? data_q : ret_q[7:0];
  assign done      = (state == S_FIN);
  assign pc_load   = done && (op_q == OP_CALL || op_q == OP_RCALL || is_ret);
  assign pc_out    = is_ret ? {mem_rdata, lo_q} : tgt_q;
  assign pop_data  = mem_rdata;
  assign irq_ack   = (done && irq_q) ? NVEC'(1) << vec_q : '0;
  assign busy      = (state != S_IDLE);
  assign sp_out    = sp;
endmodule

module stack_seq_chk #(parameter int ADDR_W = 8) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sp_out,
  input logic              iflag,
  input logic [2:0]        op_q,
  input logic              irq_q,
  input logic              pc_load
);
  AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_addr == sp_out); // R2
  AST_WRITE_DEC: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> sp_out == ADDR_W'($past(sp_out) - 1'b1)); // R2
  AST_READ_ABOVE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |-> mem_addr == ADDR_W'(sp_out + 1'b1)); // R3
  AST_READ_INC: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> sp_out == ADDR_W'($past(sp_out) + 1'b1)); // R3
  AST_RETI_SETS_I: assert property (@(posedge clk) disable iff (!rst_n) (done && op_q == 3'd5 && !irq_q) |=> iflag); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(mem_we || mem_re)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_LOAD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) pc_load |-> done); // R10
endmodule

bind stack_seq stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .sp_out(sp_out), .iflag(iflag), .op_q(op_q), .irq_q(irq_q),
  .pc_load(pc_load)
);

// File: tb/stack_seq_tb.sv
module stack_seq_tb;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [15:0] pc_in = 0, target = 0;
  logic [7:0] wr_data = 0, mem_rdata = 0, mem_wdata, pop_data;
  logic [7:0] irq_req = 0, irq_en = 0, irq_ack;
  logic [7:0] mem_addr, sp_out;
  logic mem_we, mem_re, pc_load, iflag, busy, done;
  logic [15:0] pc_out;
  logic [7:0] ram [256];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  stack_seq u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
    .target(target), .wr_data(wr_data), .irq_req(irq_req), .irq_en(irq_en),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .pc_load(pc_load), .pop_data(pop_data),
    .irq_ack(irq_ack), .iflag(iflag), .sp_out(sp_out), .busy(busy), .done(done));

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [15:0] pc, input logic [15:0] tg,
                       input logic [7:0] d, output int lat);
    @(negedge clk);
    start = 1; op = o; pc_in = pc; target = tg; wr_data = d;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic t_reset;
    check("R1 sp", sp_out, 8'hFF);
    check("R1 iflag", iflag, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_push_pop;
    int lat;
    do_op(3'd0, 0, 0, 8'hA5, lat);
    check("R2 push latency", lat, 2);
    check("R2 push byte", ram[8'hFF], 8'hA5);
    check("R2 push sp", sp_out, 8'hFE);
    do_op(3'd1, 0, 0, 0, lat);
    check("R3 pop latency", lat, 2);
    check("R3 pop data", pop_data, 8'hA5);
    check("R3 pop sp", sp_out, 8'hFF);
  endtask

  task automatic t_call_ret;
    int lat;
    do_op(3'd2, 16'h1234, 16'h0400, 0, lat);
    check("R4 call latency", lat, 3);
    check("R4 call pc", pc_out, 16'h0400);
    check("R4 call load", pc_load, 1);
    check("R4 call high", ram[8'hFF], 8'h12);
    check("R4 call low", ram[8'hFE], 8'h35);
    check("R4 call sp", sp_out, 8'hFD);
    do_op(3'd4, 0, 0, 0, lat);
    check("R5 ret latency", lat, 3);
    check("R5 ret pc", pc_out, 16'h1235);
    check("R5 ret load", pc_load, 1);
    check("R5 ret sp", sp_out, 8'hFF);
  endtask

  task automatic t_rcall_reti;
    int lat;
    do_op(3'd3, 16'h0100, 16'hFFF0, 0, lat);
    check("R4 rcall pc", pc_out, 16'h00F0);
    check("R4 rcall high", ram[8'hFF], 8'h01);
    check("R4 rcall low", ram[8'hFE], 8'h01);
    do_op(3'd5, 0, 0, 0, lat);
    check("R6 reti pc", pc_out, 16'h0101);
    check("R6 reti sp", sp_out, 8'hFF);
    @(negedge clk);
    check("R6 reti iflag", iflag, 1);
  endtask

  task automatic t_sei_cli;
    int lat;
    do_op(3'd7, 0, 0, 0, lat);
    check("R7 cli latency", lat, 1);
    check("R7 cli no load", pc_load, 0);
    @(negedge clk);
    check("R7 cli iflag", iflag, 0);
    check("R7 cli sp", sp_out, 8'hFF);
    do_op(3'd6, 0, 0, 0, lat);
    @(negedge clk);
    check("R7 sei iflag", iflag, 1);
  endtask

  task automatic t_irq_masked;
    int seen = 0;
    irq_req = 8'h04; irq_en = 8'hFB;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen++; end
    irq_req = 0;
    check("R8 masked never busy", seen, 0);
    check("R8 masked sp", sp_out, 8'hFF);
  endtask

  task automatic t_irq_take;
    int lat = 0;
    pc_in = 16'h0200; irq_en = 8'h24; irq_req = 8'h24;
    @(negedge clk);
    irq_req = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R9 irq latency", lat, 2);
    check("R9 irq pc", pc_out, 16'h0006);
    check("R9 irq ack", irq_ack, 8'h04);
    check("R9 irq high", ram[8'hFF], 8'h02);
    check("R9 irq low", ram[8'hFE], 8'h01);
    check("R9 irq sp", sp_out, 8'hFD);
  endtask

  task automatic t_start_beats_irq;
    int lat;
    @(negedge clk);
    irq_en = 8'h01; irq_req = 8'h01;
    start = 1; op = 3'd7;
    @(negedge clk);
    start = 0; irq_req = 0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R9 start precedence latency", lat, 1);
    check("R9 start precedence ack", irq_ack, 0);
    @(negedge clk);
    check("R9 start precedence iflag", iflag, 0);
    check("R9 start precedence sp", sp_out, 8'hFD);
  endtask

  task automatic t_busy_ignore;
    int lat = 1, dn = 0;
    @(negedge clk);
    start = 1; op = 3'd0; wr_data = 8'h3C;
    @(negedge clk);
    start = 1; op = 3'd1;
    @(negedge clk);
    start = 0;
    if (done) dn++;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) dn++; end
    check("R10 busy ignore sp", sp_out, 8'hFC);
    check("R10 busy ignore byte", ram[8'hFD], 8'h3C);
    check("R10 single done", dn, 1);
    check("R10 idle after", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_push_pop;
    t_call_ret;
    t_rcall_reti;
    t_sei_cli;
    t_irq_masked;
    t_irq_take;
    t_start_beats_irq;
    t_busy_ignore;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule